// File: doc/BRIEF.md
# Card Activation and Answer-to-Reset Sequencer

This block powers a contact smart card up and down in the fixed order the card standard requires, and times the card's reset line against the card's answer-to-reset. It runs on the system clock and takes two single-cycle strobes from outside. `tick` marks half of the sequencer period T. `cclk_pulse` marks one card clock pulse. Activation steps are measured in ticks. Reset release and answer timing are measured in card clock pulses, using a 16-bit window (`rst_window`) and an 8-bit early-answer extension (`early_window`).

A rising `start` with the card present, the supply good and no pending supply fault starts activation. The states run in this order:

- `ST_OSC`: the oscillator goes to its fast rate.
- `ST_CONV`: the converter starts.
- `ST_VCC`: the card supply is switched on.
- `ST_IO`: the I/O pull-up is enabled.
- `ST_RLOW`: the clock is sent with reset held low.

If `rstin` was 0 when activation was accepted, the card is synchronous and the sequence ends in `ST_SYNC` instead of `ST_RLOW`. In `ST_SYNC` the reset pin follows `rstin`.

For an asynchronous card the answer-to-reset is watched as follows:

- In `ST_RLOW`, a start bit (a falling edge on the synchronised I/O line) within the first 200 pulses is ignored.
- A later start bit in `ST_RLOW` flags the card as early and mute and parks it in `ST_HOLD`, with reset still low.
- If no start bit arrives before the window ends, reset is released and the block moves to `ST_RHIGH`.
- In `ST_RHIGH`, an answer before pulse 200 plus `early_window` flags early.
- In `ST_RHIGH`, an answer after that point is a valid answer.
- In `ST_RHIGH`, no answer within another window flags mute.
- All three outcomes of `ST_RHIGH` stop counting in `ST_RUN`.

A warm reset from `ST_HOLD` or `ST_RUN` returns to `ST_RLOW` without removing power.

Clearing `start` runs the deactivation states in this order:

- `ST_DRST`: reset goes low.
- `ST_DCLK`: the clock stops.
- `ST_DIO`: the I/O pull-up is released.
- `ST_DVCC`: the card supply is switched off.
- `ST_IDLE`: the converter and the fast oscillator turn off.

A fault, card removal or supply dropout during a session forces the same deactivation, raises `start_clr` and sets a sticky flag.

Top module: `card_atr_seq`

## Requirements
- R1: Activation (leaving `ST_IDLE` for `ST_OSC`) happens only on a rising edge of `start` while `card_present`=1, `supply_ok`=1 and `supl_flag`=0; otherwise the block stays idle with all card outputs low.
- R2: During activation `conv_en` rises 2 ticks after `osc_fast`, `vcc_en` 2 ticks after `conv_en`, `io_pullup` 6 ticks after `conv_en`, and `clk_en` exactly 8 ticks (4T) after `conv_en`; `clk_en` is never high without `io_pullup`, `vcc_en`, `conv_en` and `osc_fast`.
- R3: `rstin`=1 at acceptance selects the asynchronous flow; `rstin`=0 selects the synchronous flow, where `rst_out` equals `rstin` while the clock runs.
- R4: While reset is low, a start bit detected in the first 200 card clock pulses sets no flag and does not change `rst_out`.
- R5: With no answer, `rst_out` rises after `rst_window` pulses of the low phase; `rst_out` is only high while `clk_en` is high.
- R6: A start bit while reset is low and at or after pulse 200 sets both `early_flag` and `mute_flag`, and `rst_out` then stays low.
- R7: After reset release, a start bit before pulse 200+`early_window` sets `early_flag` only; a later start bit sets no flag and stops counting, so no mute follows; no start bit within `rst_window` pulses sets `mute_flag`.
- R8: `warm_req` in `ST_HOLD` or `ST_RUN` of an asynchronous card drives `rst_out` low with `vcc_en` kept high and sets `warm_busy`, which clears when `mute_flag` is set.
- R9: After `start` falls, `clk_en` drops 1 tick after `rst_out` falls, `io_pullup` 2 ticks after, `vcc_en` 4 ticks after, and `conv_en`/`osc_fast` 10 ticks after; `io_pullup` never stays high without `vcc_en` and `conv_en`.
- R10: In any activation or session state, `hw_fault` or loss of `card_present` sets `prot_flag`, and loss of `supply_ok` sets `supl_flag`. Any of these causes a one-cycle `start_clr` and a full deactivation.
- R11: `irq` is high while any of the four flags is set; `status_ack` clears all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low reset |
| tick | input | 1 | strobe, one per half sequencer period |
| cclk_pulse | input | 1 | strobe, one per card clock pulse |
| start | input | 1 | session command (rise activates, fall deactivates) |
| rstin | input | 1 | card type select at start; reset level in synchronous flow |
| card_present | input | 1 | card inserted |
| supply_ok | input | 1 | supply supervisor good |
| hw_fault | input | 1 | overcurrent, overheat or converter fault |
| warm_req | input | 1 | warm reset request strobe |
| status_ack | input | 1 | clears the sticky flags |
| io_in | input | 1 | card I/O line level |
| rst_window | input | 16 | reset and mute window in card clock pulses |
| early_window | input | 8 | early-answer extension past pulse 200 |
| osc_fast | output | 1 | fast oscillator select |
| conv_en | output | 1 | converter enable |
| vcc_en | output | 1 | card supply enable |
| io_pullup | output | 1 | I/O pull-up to card supply |
| clk_en | output | 1 | card clock enable |
| rst_out | output | 1 | card reset level |
| active | output | 1 | not idle |
| early_flag | output | 1 | card answered early |
| mute_flag | output | 1 | card answer missing or out of window |
| prot_flag | output | 1 | protection deactivation happened |
| supl_flag | output | 1 | supply fault seen |
| warm_busy | output | 1 | warm reset in progress |
| start_clr | output | 1 | one-cycle request to clear the start bit |
| irq | output | 1 | interrupt, any flag set |

## Verification
The properties assume that `tick` and `cclk_pulse` are single-cycle strobes. They also assume that `card_present` and `supply_ok` are sampled synchronous levels. The bench drives every input on the falling clock edge and generates both strobes from one cycle counter, with ticks far sparser than pulses. Answers are driven as a low stretch of several pulses on an otherwise high I/O line. Each answer is placed at least 50 pulses from every window edge, which absorbs the synchroniser's latency. After an emergency the bench drops `start`, as the command register would on `start_clr`.

// File: rtl/atr_seq_pkg.sv
`timescale 1ns/1ps
package atr_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OSC,
        ST_CONV,
        ST_VCC,
        ST_IO,
        ST_RLOW,
        ST_RHIGH,
        ST_HOLD,
        ST_RUN,
        ST_SYNC,
        ST_DRST,
        ST_DCLK,
        ST_DIO,
        ST_DVCC
    } seq_st_t;

    // Dwell of each timed state, in half-period ticks.
    function automatic int unsigned step_ticks(seq_st_t s);
        case (s)
            ST_OSC:  return 2;
            ST_CONV: return 2;
            ST_VCC:  return 4;
            ST_IO:   return 2;
            ST_DRST: return 1;
            ST_DCLK: return 1;
            ST_DIO:  return 2;
            ST_DVCC: return 6;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/atr_io_edge.sv
`timescale 1ns/1ps
module atr_io_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic din,
    output logic fall
);
    logic s1, s2;

    // Two stages clocked by card clock pulses; idle level is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else if (sample) begin
            s1 <= din;
            s2 <= s1;
        end
    end

    assign fall = s2 & ~s1;
endmodule

// File: rtl/atr_step_timer.sv
`timescale 1ns/1ps
module atr_step_timer #(
    parameter int TMR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [TMR_W-1:0] len,
    output logic             done
);
    logic [TMR_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (tick) cnt <= cnt + TMR_W'(1);
    end

    assign done = tick && (cnt == len - TMR_W'(1));
endmodule

// File: rtl/atr_pulse_count.sv
`timescale 1ns/1ps
module atr_pulse_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/card_atr_seq.sv
`timescale 1ns/1ps
module card_atr_seq
    import atr_seq_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int EXT_W         = 8,
    parameter int IGNORE_PULSES = 200,
    parameter int TMR_W         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cclk_pulse,
    input  logic             start,
    input  logic             rstin,
    input  logic             card_present,
    input  logic             supply_ok,
    input  logic             hw_fault,
    input  logic             warm_req,
    input  logic             status_ack,
    input  logic             io_in,
    input  logic [CNT_W-1:0] rst_window,
    input  logic [EXT_W-1:0] early_window,
    output logic             osc_fast,
    output logic             conv_en,
    output logic             vcc_en,
    output logic             io_pullup,
    output logic             clk_en,
    output logic             rst_out,
    output logic             active,
    output logic             early_flag,
    output logic             mute_flag,
    output logic             prot_flag,
    output logic             supl_flag,
    output logic             warm_busy,
    output logic             start_clr,
    output logic             irq
);
    localparam int CMP_W = CNT_W + 1;

    seq_st_t          st, nxt;
    logic             start_d, async_q;
    logic             io_fall, tmr_done, tmr_clr, cnt_inc;
    logic [CNT_W-1:0] pcnt;
    logic [CMP_W-1:0] pcnt_nx, win_lim, early_lim;
    logic             in_session, prot_cause, emerg, live, accept;
    logic             low_ans, low_exp, hi_ans, hi_early, hi_mute, warm_go;

    atr_io_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sample(cclk_pulse), .din(io_in), .fall(io_fall)
    );

    atr_step_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(tmr_clr),
        .len(TMR_W'(step_ticks(st))), .done(tmr_done)
    );

    atr_pulse_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .inc(cnt_inc), .count(pcnt)
    );

    assign in_session = (st == ST_OSC)  || (st == ST_CONV) || (st == ST_VCC) ||
                        (st == ST_IO)   || (st == ST_RLOW) || (st == ST_RHIGH) ||
                        (st == ST_HOLD) || (st == ST_RUN)  || (st == ST_SYNC);
    assign prot_cause = hw_fault | ~card_present;
    assign emerg      = in_session & (prot_cause | ~supply_ok);
    assign live       = ~emerg & start;
    assign accept     = (st == ST_IDLE) && start && !start_d &&
                        card_present && supply_ok && !supl_flag;

    assign pcnt_nx   = {1'b0, pcnt} + CMP_W'(1);
    assign win_lim   = {1'b0, rst_window};
    assign early_lim = CMP_W'(IGNORE_PULSES) + CMP_W'(early_window);

    assign low_ans  = (st == ST_RLOW) && cclk_pulse && io_fall &&
                      ({1'b0, pcnt} >= CMP_W'(IGNORE_PULSES));
    assign low_exp  = (st == ST_RLOW) && cclk_pulse && !low_ans && (pcnt_nx >= win_lim);
    assign hi_ans   = (st == ST_RHIGH) && cclk_pulse && io_fall;
    assign hi_early = hi_ans && ({1'b0, pcnt} < early_lim);
    assign hi_mute  = (st == ST_RHIGH) && cclk_pulse && !io_fall && (pcnt_nx >= win_lim);
    assign warm_go  = ((st == ST_HOLD) || (st == ST_RUN)) && warm_req && async_q;

    assign cnt_inc = cclk_pulse && ((st == ST_RLOW) || (st == ST_RHIGH));
    assign tmr_clr = (nxt != st);

    // Next-state logic
    always_comb begin
        nxt = st;
        if (in_session && (emerg || !start)) begin
            nxt = ST_DRST;
        end else begin
            unique case (st)
                ST_IDLE:          if (accept)   nxt = ST_OSC;
                ST_OSC:           if (tmr_done) nxt = ST_CONV;
                ST_CONV:          if (tmr_done) nxt = ST_VCC;
                ST_VCC:           if (tmr_done) nxt = ST_IO;
                ST_IO:            if (tmr_done) nxt = async_q ? ST_RLOW : ST_SYNC;
                ST_RLOW: begin
                    if (low_ans)      nxt = ST_HOLD;
                    else if (low_exp) nxt = ST_RHIGH;
                end
                ST_RHIGH:         if (hi_ans || hi_mute) nxt = ST_RUN;
                ST_HOLD, ST_RUN:  if (warm_go)  nxt = ST_RLOW;
                ST_SYNC:          nxt = ST_SYNC;
                ST_DRST:          if (tmr_done) nxt = ST_DCLK;
                ST_DCLK:          if (tmr_done) nxt = ST_DIO;
                ST_DIO:           if (tmr_done) nxt = ST_DVCC;
                ST_DVCC:          if (tmr_done) nxt = ST_IDLE;
                default:          nxt = ST_IDLE;
            endcase
        end
    end

    // State register and sticky status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            start_d    <= 1'b0;
            async_q    <= 1'b0;
            early_flag <= 1'b0;
            mute_flag  <= 1'b0;
            prot_flag  <= 1'b0;
            supl_flag  <= 1'b0;
            warm_busy  <= 1'b0;
            start_clr  <= 1'b0;
        end else begin
            st         <= nxt;
            start_d    <= start;
            start_clr  <= emerg;
            if (accept) async_q <= rstin;
            early_flag <= (early_flag & ~status_ack) | (live & (low_ans | hi_early));
            mute_flag  <= (mute_flag & ~status_ack)  | (live & (low_ans | hi_mute));
            prot_flag  <= (prot_flag & ~status_ack)  | (in_session & prot_cause);
            supl_flag  <= (supl_flag & ~status_ack)  | ~supply_ok;
            if (warm_go && live)
                warm_busy <= 1'b1;
            else if ((live && (low_ans || hi_mute)) || nxt == ST_DRST)
                warm_busy <= 1'b0;
        end
    end

    // Contact outputs by state
    always_comb begin
        osc_fast  = 1'b0;
        conv_en   = 1'b0;
        vcc_en    = 1'b0;
        io_pullup = 1'b0;
        clk_en    = 1'b0;
        rst_out   = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_OSC:  osc_fast = 1'b1;
            ST_CONV: {osc_fast, conv_en} = 2'b11;
            ST_VCC:  {osc_fast, conv_en, vcc_en} = 3'b111;
            ST_IO:   {osc_fast, conv_en, vcc_en, io_pullup} = 4'b1111;
            ST_RLOW, ST_HOLD, ST_DRST:
                     {osc_fast, conv_en, vcc_en, io_pullup, clk_en} = 5'b11111;
            ST_RHIGH, ST_RUN: begin
                     {osc_fast, conv_en, vcc_en, io_pullup, clk_en} = 5'b11111;
                     rst_out = 1'b1;
            end
            ST_SYNC: begin
                     {osc_fast, conv_en, vcc_en, io_pullup, clk_en} = 5'b11111;
                     rst_out = rstin;
            end
            ST_DCLK: {osc_fast, conv_en, vcc_en, io_pullup} = 4'b1111;
            ST_DIO:  {osc_fast, conv_en, vcc_en} = 3'b111;
            ST_DVCC: {osc_fast, conv_en} = 2'b11;
            default: ;
        endcase
    end

    assign active = (st != ST_IDLE);
    assign irq    = early_flag | mute_flag | prot_flag | supl_flag;
endmodule

// File: rtl/card_atr_seq_chk.sv
`timescale 1ns/1ps
module card_atr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic card_present,
    input logic supply_ok,
    input logic osc_fast,
    input logic conv_en,
    input logic vcc_en,
    input logic io_pullup,
    input logic clk_en,
    input logic rst_out,
    input logic warm_busy,
    input logic mute_flag,
    input logic prot_flag,
    input logic supl_flag,
    input logic start_clr
);
    assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_fast) |-> ($past(card_present) && $past(supply_ok)));

    assert_clk_after_io_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> (io_pullup && vcc_en && conv_en && osc_fast));

    assert_rst_needs_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |-> clk_en);

    assert_warm_ends_on_mute_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mute_flag) |-> !warm_busy);

    assert_supply_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        io_pullup |-> (vcc_en && conv_en));

    assert_emerg_flagged_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_clr |-> (prot_flag || supl_flag));
endmodule

bind card_atr_seq card_atr_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .card_present(card_present), .supply_ok(supply_ok),
    .osc_fast(osc_fast), .conv_en(conv_en), .vcc_en(vcc_en), .io_pullup(io_pullup),
    .clk_en(clk_en), .rst_out(rst_out), .warm_busy(warm_busy), .mute_flag(mute_flag),
    .prot_flag(prot_flag), .supl_flag(supl_flag), .start_clr(start_clr)
);

// File: tb/card_atr_seq_tb_top.sv
`timescale 1ns/1ps
module card_atr_seq_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, cclk_pulse = 1'b0;
    logic start = 1'b0, rstin = 1'b1, card_present = 1'b1, supply_ok = 1'b1;
    logic hw_fault = 1'b0, warm_req = 1'b0, status_ack = 1'b0, io_in = 1'b1;
    logic [15:0] rst_window = 16'd1000;
    logic [7:0]  early_window = 8'd50;
    logic osc_fast, conv_en, vcc_en, io_pullup, clk_en, rst_out, active;
    logic early_flag, mute_flag, prot_flag, supl_flag, warm_busy, start_clr, irq;

    int n_chk = 0, n_bad = 0, cyc = 0, tcount = 0, clr_cnt = 0;

    card_atr_seq dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cclk_pulse(cclk_pulse), .start(start),
        .rstin(rstin), .card_present(card_present), .supply_ok(supply_ok),
        .hw_fault(hw_fault), .warm_req(warm_req), .status_ack(status_ack), .io_in(io_in),
        .rst_window(rst_window), .early_window(early_window),
        .osc_fast(osc_fast), .conv_en(conv_en), .vcc_en(vcc_en), .io_pullup(io_pullup),
        .clk_en(clk_en), .rst_out(rst_out), .active(active), .early_flag(early_flag),
        .mute_flag(mute_flag), .prot_flag(prot_flag), .supl_flag(supl_flag),
        .warm_busy(warm_busy), .start_clr(start_clr), .irq(irq)
    );

    always #5 clk = ~clk;

    // Strobes: card pulse every 2 cycles, tick every 40 cycles.
    always @(negedge clk) begin
        cyc = cyc + 1;
        cclk_pulse = (cyc % 2 == 0);
        tick = (cyc % 40 == 0);
        if (start_clr) clr_cnt = clr_cnt + 1;
    end

    always @(posedge clk) if (tick) tcount <= tcount + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pulses(input int n);
        repeat (2 * n) @(negedge clk);
    endtask

    task automatic answer();
        @(negedge clk) io_in = 1'b0;
        wait_pulses(8);
        io_in = 1'b1;
    endtask

    task automatic activate(input logic rs, output int tc, output int tv,
                            output int ti, output int tk);
        tc = -1; tv = -1; ti = -1; tk = -1;
        @(negedge clk) begin rstin = rs; start = 1'b1; end
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (conv_en && tc < 0) tc = tcount;
            if (vcc_en && tv < 0) tv = tcount;
            if (io_pullup && ti < 0) ti = tcount;
            if (clk_en) begin tk = tcount; break; end
        end
    endtask

    task automatic deactivate();
        @(negedge clk) start = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (!active) break;
        end
    endtask

    task automatic ack();
        @(negedge clk) status_ack = 1'b1;
        @(negedge clk) status_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset active", active, 0);
        chk("R1 reset vcc", vcc_en, 0);
        chk("R11 reset irq", irq, 0);
    endtask

    task automatic t_absent();
        card_present = 1'b0;
        @(negedge clk) start = 1'b1;
        repeat (300) @(negedge clk);
        chk("R1 absent card stays idle", active, 0);
        chk("R1 absent card osc", osc_fast, 0);
        @(negedge clk) start = 1'b0;
        card_present = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_main();
        int tc, tv, ti, tk, r0, kc, kio, kv, kcv;
        activate(1'b1, tc, tv, ti, tk);
        chk("R2 vcc after conv", tv - tc, 2);
        chk("R2 io after conv", ti - tc, 6);
        chk("R2 clk 4T after conv", tk - tc, 8);
        chk("R3 async reset low", rst_out, 0);
        wait_pulses(50);
        answer();
        wait_pulses(800);
        chk("R4 ignored answer early", early_flag, 0);
        chk("R4 ignored answer mute", mute_flag, 0);
        chk("R4 reset still low", rst_out, 0);
        wait_pulses(200);
        chk("R5 reset released", rst_out, 1);
        wait_pulses(340);
        answer();
        wait_pulses(4);
        chk("R7 valid answer early", early_flag, 0);
        chk("R7 valid answer mute", mute_flag, 0);
        wait_pulses(1200);
        chk("R7 stopped counter no mute", mute_flag, 0);
        chk("R7 reset stays high", rst_out, 1);
        r0 = -1; kc = -1; kio = -1; kv = -1; kcv = -1;
        @(negedge clk) start = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (!rst_out && r0 < 0) r0 = tcount;
            if (!clk_en && kc < 0) kc = tcount;
            if (!io_pullup && kio < 0) kio = tcount;
            if (!vcc_en && kv < 0) kv = tcount;
            if (!conv_en && kcv < 0) kcv = tcount;
            if (!active) break;
        end
        chk("R9 clock stops 1 tick after reset", kc - r0, 1);
        chk("R9 io low 2 ticks after reset", kio - r0, 2);
        chk("R9 vcc off 4 ticks after reset", kv - r0, 4);
        chk("R9 converter off 10 ticks after reset", kcv - r0, 10);
        chk("R9 osc slow at end", osc_fast, 0);
    endtask

    task automatic t_low_early();
        int tc, tv, ti, tk;
        activate(1'b1, tc, tv, ti, tk);
        wait_pulses(400);
        answer();
        wait_pulses(4);
        chk("R6 early set", early_flag, 1);
        chk("R6 mute set", mute_flag, 1);
        chk("R11 irq on flags", irq, 1);
        wait_pulses(1000);
        chk("R6 reset kept low", rst_out, 0);
        deactivate();
        ack();
        @(negedge clk);
        chk("R11 ack clears irq", irq, 0);
        chk("R11 ack clears mute", mute_flag, 0);
    endtask

    task automatic t_high_early();
        int tc, tv, ti, tk;
        activate(1'b1, tc, tv, ti, tk);
        wait_pulses(1100);
        answer();
        wait_pulses(4);
        chk("R7 early in high phase", early_flag, 1);
        chk("R7 no mute on early", mute_flag, 0);
        chk("R7 reset high", rst_out, 1);
        deactivate();
        ack();
    endtask

    task automatic t_warm();
        int tc, tv, ti, tk;
        activate(1'b1, tc, tv, ti, tk);
        wait_pulses(1400);
        answer();
        wait_pulses(4);
        chk("R8 running before warm", mute_flag, 0);
        @(negedge clk) warm_req = 1'b1;
        @(negedge clk) warm_req = 1'b0;
        @(negedge clk);
        chk("R8 warm reset low", rst_out, 0);
        chk("R8 warm keeps vcc", vcc_en, 1);
        chk("R8 warm busy", warm_busy, 1);
        wait_pulses(1050);
        chk("R8 warm release", rst_out, 1);
        wait_pulses(1050);
        chk("R8 mute after warm", mute_flag, 1);
        chk("R8 no early after warm", early_flag, 0);
        chk("R8 warm busy cleared", warm_busy, 0);
        deactivate();
        ack();
    endtask

    task automatic t_sync();
        int tc, tv, ti, tk;
        activate(1'b0, tc, tv, ti, tk);
        chk("R3 sync clock on", clk_en, 1);
        chk("R3 sync reset follows 0", rst_out, 0);
        @(negedge clk) rstin = 1'b1;
        @(negedge clk);
        chk("R3 sync reset follows 1", rst_out, 1);
        @(negedge clk) rstin = 1'b0;
        @(negedge clk);
        chk("R3 sync reset back low", rst_out, 0);
        deactivate();
    endtask

    task automatic t_fault();
        int tc, tv, ti, tk, c0;
        activate(1'b1, tc, tv, ti, tk);
        wait_pulses(20);
        c0 = clr_cnt;
        @(negedge clk) hw_fault = 1'b1;
        @(negedge clk) hw_fault = 1'b0;
        @(negedge clk);
        chk("R10 prot set", prot_flag, 1);
        chk("R10 irq", irq, 1);
        chk("R10 start_clr once", clr_cnt - c0, 1);
        chk("R10 reset low", rst_out, 0);
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (!active) break;
        end
        chk("R10 vcc off after emergency", vcc_en, 0);
        @(negedge clk) start = 1'b0;
        ack();
    endtask

    task automatic t_supply();
        int tc, tv, ti, tk;
        activate(1'b1, tc, tv, ti, tk);
        wait_pulses(20);
        @(negedge clk) supply_ok = 1'b0;
        repeat (3) @(negedge clk);
        supply_ok = 1'b1;
        chk("R10 supl set", supl_flag, 1);
        chk("R10 prot not set on dropout", prot_flag, 0);
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (!active) break;
        end
        @(negedge clk) start = 1'b0;
        @(negedge clk) start = 1'b1;
        repeat (300) @(negedge clk);
        chk("R1 blocked by supl", active, 0);
        @(negedge clk) start = 1'b0;
        ack();
        activate(1'b1, tc, tv, ti, tk);
        chk("R1 activates after ack", clk_en, 1);
        deactivate();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_absent();
        t_main();
        t_low_early();
        t_high_early();
        t_warm();
        t_sync();
        t_fault();
        t_supply();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_900_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule